// File: doc/BRIEF.md
# Quad-Channel Converter Register File

This block holds the register state of a four-channel analog-to-digital converter slave. It keeps 24 bytes in three pages of eight. The first page holds the conversion results. The second holds each channel's control and status bits. The third holds each channel's alarm thresholds. A bus command engine reaches every byte through a single-byte read/write port. The converter delivers finished results through a separate load port that carries a channel index, a 16-bit value and a valid strobe.

When a result is loaded, the block masks it to the channel's programmed resolution and stores it. It then compares the top eight bits with the channel's two thresholds and updates the channel's high and low alarm flags. Two outputs are derived from the stored state. One is a per-channel open-drain drive for channels used as digital outputs. The other is a single flag telling the bus engine that the device should take part in a conditional search. That flag is set when an enabled alarm is pending or when a device-wide power-on indicator is set.

Top module: `adc_regfile`

## Requirements
- R1: Byte address 2c+k (k = 0 low byte, 1 high byte) reads result of channel c, 08h+2c+k reads control byte k of channel c, 10h+2c reads the low threshold and 11h+2c the high threshold; reads at 18h..1Fh return 00h; read data is combinational from the address.
- R2: After reset, results read 00h, control byte 0 reads 08h, control byte 1 reads 8Ch, low thresholds read 00h and high thresholds read FFh.
- R3: Bus writes to addresses 00h..07h and 18h..1Fh change no readable byte and no output.
- R4: A loaded result is stored with only its top N bits kept, the rest zero, where N is the channel's resolution code in control byte 0 bits 3:0, and code 0 means N = 16.
- R5: Control byte 0 bits 5:4 and control byte 1 bits 6 and 1 always read 0, whatever is written.
- R6: In the cycle after a load strobe, the channel's high flag (control byte 1 bit 5) is 1 exactly when the stored result's top 8 bits exceed the high threshold. The low flag (bit 4) is 1 exactly when they are below the low threshold. A non-alarming result clears the flag.
- R7: When N < 8, the low 8-N bits of both thresholds are ignored in the comparison.
- R8: A bus write to control byte 1 can clear either alarm flag but never set it. Bit 0 (range), bit 2 (low alarm enable) and bit 3 (high alarm enable) take the written value.
- R9: Bit 7 of every channel's control byte 1 reads one shared power-on flag. It is 1 after reset and takes bit 7 of the most recent write to any channel's control byte 1.
- R10: search_hit is 1 exactly when the power-on flag is 1, or when some channel has (bit 3 and bit 5) or (bit 2 and bit 4) set in control byte 1.
- R11: pin_drive[c] is 1 exactly when channel c's control byte 0 has bit 7 (output enable) = 1 and bit 6 (output level) = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ld_valid | input | 1 | Result load strobe |
| ld_chan | input | 2 | Channel being loaded |
| ld_value | input | 16 | Raw converter result |
| pin_drive | output | 4 | Per-channel open-drain pull-down enable |
| search_hit | output | 1 | Device should answer a conditional search |

## Verification
The checker watches, on every cycle, that the reserved bits read zero and that the unused page reads zero. It also checks that a result-page write leaves the read data unchanged, that a write of the power-on bit raises search_hit, and that output-enable writes drive or release the addressed pin on the next cycle. Resolution masking, the threshold comparison with masked low bits, the clear-only behaviour of the alarm flags and the sharing of the power-on bit across channels depend on data values. These are shown only by the bench's scenarios, which compare every byte and both outputs against a behavioural model.

// File: rtl/adc_regfile_pkg.sv
package adc_regfile_pkg;

    localparam int NCH     = 4;
    localparam int RES_W   = 16;
    localparam int TH_W    = 8;
    localparam int CH_W    = $clog2(NCH);
    localparam int ADDR_W  = 5;
    localparam int RC_W    = 4;
    localparam int NBITS_W = $clog2(RES_W) + 1;

    typedef struct packed {
        logic            oe;
        logic            oc;
        logic [RC_W-1:0] rc;
    } ctl0_t;

    typedef struct packed {
        logic afh;
        logic afl;
        logic aeh;
        logic ael;
        logic ir;
    } ctl1_t;

    typedef struct packed {
        logic [NCH-1:0][RES_W-1:0] res;
        ctl0_t [NCH-1:0]           c0;
        ctl1_t [NCH-1:0]           c1;
        logic [NCH-1:0][TH_W-1:0]  lo;
        logic [NCH-1:0][TH_W-1:0]  hi;
        logic                      por;
    } regs_t;

    function automatic logic [NBITS_W-1:0] res_bits(input logic [RC_W-1:0] rc);
        return (rc == '0) ? NBITS_W'(RES_W) : NBITS_W'(rc);
    endfunction

endpackage

// File: rtl/adc_alarm_eval.sv
module adc_alarm_eval
    import adc_regfile_pkg::*;
(
    input  logic [RES_W-1:0] raw,
    input  logic [RC_W-1:0]  rc,
    input  logic [TH_W-1:0]  th_lo,
    input  logic [TH_W-1:0]  th_hi,
    output logic [RES_W-1:0] kept,
    output logic             flag_hi,
    output logic             flag_lo
);
    logic [NBITS_W-1:0] nbits;
    logic [NBITS_W-1:0] drop_res;
    logic [NBITS_W-1:0] drop_th;
    logic [TH_W-1:0]    th_mask;
    logic [TH_W-1:0]    top;

    always_comb begin
        nbits    = res_bits(rc);
        drop_res = NBITS_W'(RES_W) - nbits;
        kept     = raw & ({RES_W{1'b1}} << drop_res);
        top      = kept[RES_W-1 -: TH_W];
        if (nbits >= NBITS_W'(TH_W)) begin
            drop_th = '0;
        end else begin
            drop_th = NBITS_W'(TH_W) - nbits;
        end
        th_mask = {TH_W{1'b1}} << drop_th;
        flag_hi = top > (th_hi & th_mask);
        flag_lo = top < (th_lo & th_mask);
    end
endmodule

// File: rtl/adc_search_or.sv
module adc_search_or
    import adc_regfile_pkg::*;
(
    input  ctl1_t [NCH-1:0] c1,
    input  logic            por,
    output logic            hit
);
    logic [NCH-1:0] ch_hit;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign ch_hit[i] = (c1[i].aeh & c1[i].afh) | (c1[i].ael & c1[i].afl);
    end

    assign hit = por | (|ch_hit);
endmodule

// File: rtl/adc_regfile.sv
module adc_regfile
    import adc_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ld_valid,
    input  logic [CH_W-1:0]   ld_chan,
    input  logic [RES_W-1:0]  ld_value,
    output logic [NCH-1:0]    pin_drive,
    output logic              search_hit
);
    localparam logic [1:0] PG_RES = 2'd0;
    localparam logic [1:0] PG_CTL = 2'd1;
    localparam logic [1:0] PG_TH  = 2'd2;

    regs_t regs_d, regs_q;

    logic [1:0]       pg;
    logic [CH_W-1:0]  ach;
    logic             hb;
    logic [RES_W-1:0] ev_kept;
    logic             ev_hi, ev_lo;

    assign pg  = bus_addr[4:3];
    assign ach = bus_addr[2:1];
    assign hb  = bus_addr[0];

    adc_alarm_eval u_eval (
        .raw     (ld_value),
        .rc      (regs_q.c0[ld_chan].rc),
        .th_lo   (regs_q.lo[ld_chan]),
        .th_hi   (regs_q.hi[ld_chan]),
        .kept    (ev_kept),
        .flag_hi (ev_hi),
        .flag_lo (ev_lo)
    );

    adc_search_or u_search (
        .c1  (regs_q.c1),
        .por (regs_q.por),
        .hit (search_hit)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_pin
        assign pin_drive[i] = regs_q.c0[i].oe & ~regs_q.c0[i].oc;
    end

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            case (pg)
                PG_CTL: begin
                    if (!hb) begin
                        regs_d.c0[ach].oe = bus_wdata[7];
                        regs_d.c0[ach].oc = bus_wdata[6];
                        regs_d.c0[ach].rc = bus_wdata[3:0];
                    end else begin
                        regs_d.c1[ach].ir  = bus_wdata[0];
                        regs_d.c1[ach].ael = bus_wdata[2];
                        regs_d.c1[ach].aeh = bus_wdata[3];
                        regs_d.c1[ach].afl = regs_q.c1[ach].afl & bus_wdata[4];
                        regs_d.c1[ach].afh = regs_q.c1[ach].afh & bus_wdata[5];
                        regs_d.por         = bus_wdata[7];
                    end
                end
                PG_TH: begin
                    if (!hb) regs_d.lo[ach] = bus_wdata;
                    else     regs_d.hi[ach] = bus_wdata;
                end
                default: ;
            endcase
        end
        if (ld_valid) begin
            regs_d.res[ld_chan]    = ev_kept;
            regs_d.c1[ld_chan].afh = ev_hi;
            regs_d.c1[ld_chan].afl = ev_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.res <= '0;
            regs_q.lo  <= '0;
            regs_q.hi  <= '1;
            regs_q.por <= 1'b1;
            for (int i = 0; i < NCH; i++) begin
                regs_q.c0[i] <= '{oe: 1'b0, oc: 1'b0, rc: 4'd8};
                regs_q.c1[i] <= '{afh: 1'b0, afl: 1'b0, aeh: 1'b1, ael: 1'b1, ir: 1'b0};
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (pg)
            PG_RES: bus_rdata = hb ? regs_q.res[ach][15:8] : regs_q.res[ach][7:0];
            PG_CTL: begin
                if (!hb) begin
                    bus_rdata = {regs_q.c0[ach].oe, regs_q.c0[ach].oc, 2'b00, regs_q.c0[ach].rc};
                end else begin
                    bus_rdata = {regs_q.por, 1'b0, regs_q.c1[ach].afh, regs_q.c1[ach].afl,
                                 regs_q.c1[ach].aeh, regs_q.c1[ach].ael, 1'b0, regs_q.c1[ach].ir};
                end
            end
            PG_TH:   bus_rdata = hb ? regs_q.hi[ach] : regs_q.lo[ach];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_regfile_chk.sv
module adc_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic [4:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       ld_valid,
    input logic [3:0] pin_drive,
    input logic       search_hit
);
    assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[4:3] == 2'b11) |-> (bus_rdata == 8'h00));

    assert_resv_ctl0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[4:3] == 2'b01 && !bus_addr[0]) |-> (bus_rdata[5:4] == 2'b00));

    assert_resv_ctl1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[4:3] == 2'b01 && bus_addr[0]) |-> (bus_rdata[6] == 1'b0 && bus_rdata[1] == 1'b0));

    assert_result_page_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[4:3] == 2'b00 && !ld_valid)
        |=> (!$stable(bus_addr) || $stable(bus_rdata)));

    assert_por_write_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[4:3] == 2'b01 && bus_addr[0] && bus_wdata[7]) |=> search_hit);

    assert_pin_drive_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[4:3] == 2'b01 && !bus_addr[0] && bus_wdata[7:6] == 2'b10)
        |=> pin_drive[$past(bus_addr[2:1])]);

    assert_pin_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[4:3] == 2'b01 && !bus_addr[0] && !bus_wdata[7])
        |=> !pin_drive[$past(bus_addr[2:1])]);
endmodule

bind adc_regfile adc_regfile_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ld_valid   (ld_valid),
    .pin_drive  (pin_drive),
    .search_hit (search_hit)
);

// File: tb/adc_regfile_tb.sv
module adc_regfile_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_we = 0;
    logic [4:0]  bus_addr = 0;
    logic [7:0]  bus_wdata = 0;
    logic [7:0]  bus_rdata;
    logic        ld_valid = 0;
    logic [1:0]  ld_chan = 0;
    logic [15:0] ld_value = 0;
    logic [3:0]  pin_drive;
    logic        search_hit;

    int tests = 0;
    int fails = 0;
    bit live = 0;
    bit done = 0;

    // behavioural model: byte image plus a separate power-on bit
    logic [7:0] mem [0:23];
    logic       m_por;

    always #10 clk = ~clk;

    adc_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ld_valid(ld_valid),
        .ld_chan(ld_chan), .ld_value(ld_value), .pin_drive(pin_drive),
        .search_hit(search_hit)
    );

    function automatic logic [7:0] m_read(input int a);
        if (a >= 24) return 8'h00;
        if (a >= 8 && a < 16 && (a % 2) == 1) return {m_por, mem[a][6:0]};
        return mem[a];
    endfunction

    function automatic logic m_hit();
        logic h = m_por;
        for (int c = 0; c < 4; c++) begin
            logic [7:0] b = mem[9 + 2*c];
            if ((b[3] && b[5]) || (b[2] && b[4])) h = 1;
        end
        return h;
    endfunction

    function automatic logic [3:0] m_pins();
        logic [3:0] p;
        for (int c = 0; c < 4; c++) p[c] = mem[8 + 2*c][7] && !mem[8 + 2*c][6];
        return p;
    endfunction

    task automatic m_reset();
        for (int c = 0; c < 4; c++) begin
            mem[2*c] = 0; mem[2*c+1] = 0;
            mem[8+2*c] = 8'h08; mem[9+2*c] = 8'h0C;
            mem[16+2*c] = 8'h00; mem[17+2*c] = 8'hFF;
        end
        m_por = 1;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a[4:0]; bus_wdata = d;
        @(posedge clk);
        if (a >= 8 && a < 16) begin
            if (a % 2 == 0) mem[a] = d & 8'hCF;
            else begin
                mem[a] = (mem[a] & d & 8'h30) | (d & 8'h0D);
                m_por = d[7];
            end
        end else if (a >= 16 && a < 24) mem[a] = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic ld(input int c, input logic [15:0] v);
        int bits;
        logic [15:0] kept;
        logic [7:0] top, m, lo, hi;
        @(negedge clk);
        ld_valid = 1; ld_chan = c[1:0]; ld_value = v;
        @(posedge clk);
        bits = (mem[8+2*c][3:0] == 0) ? 16 : int'(mem[8+2*c][3:0]);
        kept = 0;
        for (int b = 16 - bits; b < 16; b++) kept[b] = v[b];
        top = kept[15:8];
        m = 8'hFF;
        if (bits < 8) for (int b = 0; b < 8 - bits; b++) m[b] = 0;
        lo = mem[16+2*c] & m; hi = mem[17+2*c] & m;
        mem[2*c] = kept[7:0]; mem[2*c+1] = kept[15:8];
        mem[9+2*c][5] = (top > hi);
        mem[9+2*c][4] = (top < lo);
        @(negedge clk);
        ld_valid = 0;
    endtask

    task automatic rd(input int a, input string req);
        @(negedge clk);
        bus_addr = a[4:0];
        #2;
        check(req, {8'h00, bus_rdata}, {8'h00, m_read(a)});
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 32; a++) rd(a, req);
    endtask

    // every-cycle comparison of both outputs
    always @(negedge clk) begin
        if (live) begin
            check("R10 search_hit", {15'd0, search_hit}, {15'd0, m_hit()});
            check("R11 pin_drive", {12'd0, pin_drive}, {12'd0, m_pins()});
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        live = 1;
        sweep("R2 R1 reset map");

        // R3: result page and unused page writes ignored
        wr(3, 8'hA5); wr(24, 8'h5A); wr(31, 8'hFF);
        sweep("R3 ignored writes");

        // R5 reserved bits, R11 pin control
        wr(8 + 2, 8'h80);
        wr(8 + 4, 8'hC0);
        wr(8 + 6, 8'h7F);
        wr(9 + 6, 8'h4E);
        sweep("R5 R11 control bytes");
        wr(8 + 2, 8'h48);
        rd(10, "R11 release");

        // R9: shared power-on bit
        wr(9, 8'h0C);
        rd(11, "R9 por cleared via ch0");
        wr(9 + 4, 8'h8C);
        rd(9, "R9 por set via ch2");
        rd(15, "R9 por set via ch2");
        wr(9 + 4, 8'h0C);
        wr(9 + 6, 8'h0C);
        rd(9, "R9 por cleared");

        // R6: alarms on channel 0, resolution 8
        wr(16, 8'h40); wr(17, 8'hC0);
        ld(0, 16'hD123);
        rd(0, "R4 res8 low byte"); rd(1, "R4 res8 high byte"); rd(9, "R6 high flag");
        ld(0, 16'h80FF);
        rd(9, "R6 cleared");
        ld(0, 16'h10AA);
        rd(9, "R6 low flag");
        ld(0, 16'hC0FF);
        rd(9, "R6 equal high not alarm");

        // R7: resolution 4 masks threshold low bits
        wr(8 + 2, 8'h04);
        wr(16 + 2, 8'h35); wr(17 + 2, 8'h3F);
        ld(1, 16'h3FFF);
        rd(2, "R4 res4"); rd(3, "R4 res4"); rd(11, "R7 masked no alarm");
        ld(1, 16'h4000);
        rd(11, "R7 high after mask");

        // R8: flags clear-only
        wr(11, 8'h3C);
        rd(11, "R8 flag kept");
        wr(11, 8'h0C);
        rd(11, "R8 flag cleared");
        wr(11, 8'h3D);
        rd(11, "R8 cannot set flag");

        // R4: full and 15-bit resolution
        wr(8 + 4, 8'h00);
        ld(2, 16'hABCD);
        rd(4, "R4 res16"); rd(5, "R4 res16");
        wr(8 + 6, 8'h0F);
        ld(3, 16'hFFFF);
        rd(6, "R4 res15"); rd(7, "R4 res15");

        // R3: result writes after loads
        wr(4, 8'h00); wr(7, 8'h00);
        rd(4, "R3 result kept"); rd(7, "R3 result kept");

        // R10: low alarm enable gating
        wr(9, 8'h08);
        ld(0, 16'h1000);
        rd(9, "R10 low flag no enable");
        wr(9, 8'h1C);
        sweep("R1 final map");

        live = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule